// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects up to eight interrupt inputs, keeps a pending register, an in-service register and a mask register, and picks a single winner by fixed priority. Input 0 has the highest priority. The winner raises `int_out`. When the processor side pulses `ack`, the block places an 8-bit vector on `vec_out` and moves the winning request into service.

A host programs the block through two byte-wide locations. The command location (`reg_sel` = 0) takes an initialization trigger, read-select commands and specific end-of-interrupt commands. The data location (`reg_sel` = 1) takes the initialization words and, in normal operation, the mask. Initialization is a small state machine with four states. `ST_READY` moves to `ST_WAIT_BASE` on the trigger command. `ST_WAIT_BASE` moves to `ST_WAIT_CASC` on the next data write, which sets the vector base. `ST_WAIT_CASC` moves to `ST_WAIT_MODE` on the next data write, which sets the cascade word. `ST_WAIT_MODE` returns to `ST_READY` on the next data write, which sets the mode word. A trigger command in any state restarts the sequence at `ST_WAIT_BASE`.

Two instances can be chained. Tie `role_slave` low on the master and high on the slave. Connect the slave's `int_out` to a master input, and connect the master's cascade outputs to the slave's cascade inputs. A shared `ack` then causes the slave to supply the vector.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the pending and in-service registers are 0, command-location reads return the pending register, and `int_out` is low.
- R2: Writing 0x11 to the command location clears the in-service register and the read select. The next three data writes are taken, in this order, as the vector base, the cascade word and the mode word. None of these three writes alters the mask.
- R3: In `ST_READY` a data write loads the mask, and a data read returns it. A mask bit of 1 blocks that input from `int_out`, so a mask of 0xFF keeps `int_out` low.
- R4: Command 0x0A makes command-location reads return the pending register. Command 0x0B makes them return the in-service register.
- R5: A rising edge on an input sets its pending bit whether or not the input is masked. The bit clears again if the input falls before acknowledge.
- R6: `int_out` is high exactly when some unmasked pending input has a lower index than every in-service bit. The lowest such index wins.
- R7: When `ack` is pulsed with a winner, the next cycle shows `vec_vld` high with `vec_out` = base + winner index. The winner's pending bit clears.
- R8: Command 0x60+n (n in 0–7) clears in-service bit n only.
- R9: When bit 1 of the mode word is set, acknowledge leaves the in-service register unchanged.
- R10: When `ack` is pulsed with no winner, the vector is base + 7 and no in-service bit is set. This holds even if input 7 is masked.
- R11: On a master, when the winning input's bit is set in the cascade word, `cas_out_vld` is high during the `ack` cycle and `cas_out` equals that input's index. The master sets that in-service bit and supplies no vector.
- R12: A slave answers `ack` only when `cas_in_vld` is high and `cas_in` equals bits 2:0 of its cascade word. Otherwise its vector output and its registers are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command location, 1 selects the data location |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the location selected by `reg_sel` |
| irq_in | input | 8 | Interrupt inputs, edge sensitive |
| int_out | output | 1 | Interrupt request to the processor or master |
| ack | input | 1 | Acknowledge pulse |
| vec_vld | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | 8 | Interrupt vector |
| role_slave | input | 1 | 1 makes this instance a slave |
| cas_out | output | 3 | Index of the master input that leads to a slave |
| cas_out_vld | output | 1 | `cas_out` is meaningful |
| cas_in | input | 3 | Cascade index received by a slave |
| cas_in_vld | input | 1 | `cas_in` is meaningful |

## Verification
The bench sweeps every master input and every slave input one at a time. Each sweep computes the vector arithmetically from the base, which separates correct index encoding from off-by-one or swapped-bit faults. Overlapping requests and nested service cover both the lowest-index rule and blocking by an in-service bit. A request that drops before acknowledge exercises the spurious vector under an input-7 mask. A mode-word reprogram checks automatic end-of-interrupt against the specific-command path. A master-owned acknowledge while the slave is pending shows that the slave stays silent when the cascade select does not match.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned NUM_IN   = 8;
    localparam int unsigned DW       = 8;
    localparam int unsigned AEOI_BIT = 1;

    localparam logic [7:0] CMD_INIT   = 8'h11;
    localparam logic [7:0] CMD_RD_REQ = 8'h0A;
    localparam logic [7:0] CMD_RD_SVC = 8'h0B;
    localparam logic [4:0] CMD_EOI_HI = 5'b01100;

    typedef enum logic [1:0] {
        ST_READY,
        ST_WAIT_BASE,
        ST_WAIT_CASC,
        ST_WAIT_MODE
    } prog_state_e;
endpackage

// File: rtl/pic_prog_fsm.sv
module pic_prog_fsm
    import pic_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 port_data,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         imr_o,
    output logic [W-1:0]         base_o,
    output logic [W-1:0]         casc_o,
    output logic                 aeoi_o,
    output logic                 rd_svc_o,
    output logic                 init_o,
    output logic                 eoi_vld_o,
    output logic [$clog2(W)-1:0] eoi_lvl_o,
    output prog_state_e          state_o
);
    localparam int unsigned LW = $clog2(W);

    prog_state_e state_q, state_d;

    logic cmd_wr, data_wr;
    assign cmd_wr  = wr_en && !port_data;
    assign data_wr = wr_en && port_data;
    assign init_o  = cmd_wr && (wdata == CMD_INIT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (init_o) begin
            state_d = ST_WAIT_BASE;
        end else begin
            unique case (state_q)
                ST_READY:     state_d = ST_READY;
                ST_WAIT_BASE: if (data_wr) state_d = ST_WAIT_CASC;
                ST_WAIT_CASC: if (data_wr) state_d = ST_WAIT_MODE;
                ST_WAIT_MODE: if (data_wr) state_d = ST_READY;
                default:      state_d = ST_READY;
            endcase
        end
    end

    // output / configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_o    <= '1;
            base_o   <= '0;
            casc_o   <= '0;
            aeoi_o   <= 1'b0;
            rd_svc_o <= 1'b0;
        end else if (init_o) begin
            rd_svc_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_READY: begin
                    if (data_wr) imr_o <= wdata;
                    if (cmd_wr && wdata == CMD_RD_REQ) rd_svc_o <= 1'b0;
                    if (cmd_wr && wdata == CMD_RD_SVC) rd_svc_o <= 1'b1;
                end
                ST_WAIT_BASE: if (data_wr) base_o <= wdata;
                ST_WAIT_CASC: if (data_wr) casc_o <= wdata;
                ST_WAIT_MODE: if (data_wr) aeoi_o <= wdata[AEOI_BIT];
                default: ;
            endcase
        end
    end

    assign eoi_vld_o = cmd_wr && (state_q == ST_READY) && (wdata[W-1:LW] == CMD_EOI_HI);
    assign eoi_lvl_o = wdata[LW-1:0];
    assign state_o   = state_q;
endmodule

// File: rtl/pic_req_reg.sv
module pic_req_reg #(
    parameter int unsigned N = pic_pkg::NUM_IN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] irr_o
);
    logic [N-1:0] irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            irr_o <= '0;
        end else begin
            irq_q <= irq_i;
            irr_o <= (irr_o | (irq_i & ~irq_q)) & irq_i & ~clr_i;
        end
    end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int unsigned N = pic_pkg::NUM_IN
) (
    input  logic [N-1:0]         irr,
    input  logic [N-1:0]         imr,
    input  logic [N-1:0]         isr,
    output logic                 win_vld,
    output logic [$clog2(N)-1:0] win_idx
);
    localparam int unsigned IW = $clog2(N);

    always_comb begin
        logic stop;
        stop    = 1'b0;
        win_vld = 1'b0;
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!stop) begin
                if (isr[i]) begin
                    stop = 1'b1;
                end else if (irr[i] && !imr[i]) begin
                    win_vld = 1'b1;
                    win_idx = IW'(i);
                    stop    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned N = NUM_IN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [N-1:0]         reg_wdata,
    output logic [N-1:0]         reg_rdata,
    input  logic [N-1:0]         irq_in,
    output logic                 int_out,
    input  logic                 ack,
    output logic                 vec_vld,
    output logic [N-1:0]         vec_out,
    input  logic                 role_slave,
    output logic [$clog2(N)-1:0] cas_out,
    output logic                 cas_out_vld,
    input  logic [$clog2(N)-1:0] cas_in,
    input  logic                 cas_in_vld
);
    localparam int unsigned IW = $clog2(N);

    logic [N-1:0]  imr_w, base_w, casc_w, irr_w, clr_w, isr_q, eoi_mask, grant_mask;
    logic          aeoi_w, rd_svc_w, init_w, eoi_vld_w, win_vld, respond, to_slave, grant;
    logic [IW-1:0] eoi_lvl_w, win_idx;
    prog_state_e   state_w;

    pic_prog_fsm #(.W(N)) u_prog (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .port_data(reg_sel),
        .wdata(reg_wdata), .imr_o(imr_w), .base_o(base_w), .casc_o(casc_w),
        .aeoi_o(aeoi_w), .rd_svc_o(rd_svc_w), .init_o(init_w),
        .eoi_vld_o(eoi_vld_w), .eoi_lvl_o(eoi_lvl_w), .state_o(state_w)
    );

    pic_req_reg #(.N(N)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_in), .clr_i(clr_w), .irr_o(irr_w)
    );

    pic_prio #(.N(N)) u_prio (
        .irr(irr_w), .imr(imr_w), .isr(isr_q), .win_vld(win_vld), .win_idx(win_idx)
    );

    assign respond    = ack && (!role_slave || (cas_in_vld && cas_in == casc_w[IW-1:0]));
    assign to_slave   = !role_slave && win_vld && casc_w[win_idx];
    assign grant      = respond && win_vld;
    assign grant_mask = grant ? (N'(1) << win_idx) : '0;
    assign clr_w      = grant_mask;
    assign eoi_mask   = eoi_vld_w ? (N'(1) << eoi_lvl_w) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)      isr_q <= '0;
        else if (init_w) isr_q <= '0;
        else             isr_q <= (isr_q & ~eoi_mask) | (aeoi_w ? '0 : grant_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_vld <= 1'b0;
            vec_out <= '0;
        end else begin
            vec_vld <= respond && !to_slave;
            if (respond)
                vec_out <= base_w + (win_vld ? N'(win_idx) : N'(N - 1));
        end
    end

    assign int_out     = win_vld;
    assign cas_out_vld = ack && to_slave;
    assign cas_out     = (ack && to_slave) ? win_idx : '0;
    assign reg_rdata   = reg_sel ? imr_w : (rd_svc_w ? isr_q : irr_w);
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk
    import pic_pkg::*;
#(
    parameter int unsigned N = NUM_IN
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_wr,
    input logic         reg_sel,
    input logic [N-1:0] reg_wdata,
    input logic         ack,
    input logic         role_slave,
    input logic         int_out,
    input logic         vec_vld,
    input logic [N-1:0] vec_out,
    input logic [N-1:0] imr,
    input logic [N-1:0] irr,
    input logic [N-1:0] isr,
    input logic [N-1:0] base,
    input logic         aeoi,
    input prog_state_e  state
);
    assert_vec_follows_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> $past(ack));

    assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && state == ST_READY) |=> imr == $past(reg_wdata));

    assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && state == ST_READY && reg_wdata[7:3] == CMD_EOI_HI && !ack)
        |=> !isr[$past(reg_wdata[2:0])]);

    assert_int_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != '0));

    assert_auto_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (aeoi && ack && !reg_wr) |=> isr == $past(isr));

    assert_spurious_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !role_slave && !int_out) |=> (vec_vld && vec_out == $past(base) + 8'd7));

    assert_init_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_MODE && reg_wr && reg_sel && reg_wdata != CMD_INIT) |=> state == ST_READY);
endmodule

bind pic_ctrl pic_ctrl_chk #(.N(N)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ack(ack), .role_slave(role_slave),
    .int_out(int_out), .vec_vld(vec_vld), .vec_out(vec_out),
    .imr(imr_w), .irr(irr_w), .isr(isr_q), .base(base_w),
    .aeoi(aeoi_w), .state(state_w)
);

// File: tb/pic_ctrl_tb.sv
`timescale 1ns/1ps
module pic_ctrl_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_sel = 0;
    logic [7:0] reg_wdata = 0;
    logic       m_wr = 0, s_wr = 0, ack = 0;
    logic [7:0] m_irq = 0, s_irq = 0;
    logic [7:0] m_rdata, s_rdata, m_vec, s_vec;
    logic       m_int, s_int, m_vv, s_vv, m_cv, s_cv;
    logic [2:0] m_cas, s_cas;
    logic [7:0] m_irq_bus;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign m_irq_bus = {m_irq[7:3], s_int, m_irq[1:0]};

    pic_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(m_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(m_rdata), .irq_in(m_irq_bus), .int_out(m_int), .ack(ack),
        .vec_vld(m_vv), .vec_out(m_vec), .role_slave(1'b0), .cas_out(m_cas),
        .cas_out_vld(m_cv), .cas_in(3'd0), .cas_in_vld(1'b0)
    );

    pic_ctrl slave_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(s_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(s_rdata), .irq_in(s_irq), .int_out(s_int), .ack(ack),
        .vec_vld(s_vv), .vec_out(s_vec), .role_slave(1'b1), .cas_out(s_cas),
        .cas_out_vld(s_cv), .cas_in(m_cas), .cas_in_vld(m_cv)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input bit to_slave, input bit sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; m_wr = !to_slave; s_wr = to_slave;
        @(negedge clk);
        m_wr = 0; s_wr = 0;
    endtask

    task automatic rd(input bit from_slave, input bit sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = from_slave ? s_rdata : m_rdata;
    endtask

    logic       got_cv, got_mvv, got_svv;
    logic [2:0] got_cas;
    logic [7:0] got_vec;

    task automatic do_ack();
        @(negedge clk);
        ack = 1;
        #1 got_cv = m_cv; got_cas = m_cas;
        @(negedge clk);
        ack = 0;
        got_mvv = m_vv; got_svv = s_vv;
        got_vec = m_vv ? m_vec : s_vec;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        wait_cyc(4);
        rst_n = 1;
        wait_cyc(1);
        // R1 reset state
        rd(0, 1, v); check("R1 mask", v, 8'hFF);
        rd(0, 0, v); check("R1 pending", v, 8'h00);
        check("R1 int_out", {7'd0, m_int}, 8'h00);

        // R2 program master (base 0x20, slave on input 2) and slave (base 0x28, id 2)
        wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
        wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
        rd(0, 1, v); check("R2 mask untouched by init", v, 8'hFF);

        // R5/R3 masked input still latches pending, no int_out
        @(negedge clk); m_irq[3] = 1;
        wait_cyc(2);
        check("R3 masked int_out", {7'd0, m_int}, 8'h00);
        rd(0, 0, v); check("R5 pending set while masked", v, 8'h08);
        @(negedge clk); m_irq[3] = 0;
        wait_cyc(2);
        rd(0, 0, v); check("R5 pending clears on fall", v, 8'h00);

        wr(0, 1, 8'h00); wr(1, 1, 8'h00);
        rd(0, 1, v); check("R3 mask readback", v, 8'h00);
        wr(0, 0, 8'h0B); wr(1, 0, 8'h0B);

        // R7 sweep of master inputs
        for (int n = 0; n < 8; n++) begin
            if (n != 2) begin
                @(negedge clk); m_irq[n] = 1;
                wait_cyc(2);
                check("R6 int_out", {7'd0, m_int}, 8'h01);
                do_ack();
                check("R7 vector", got_vec, 8'h20 + 8'(n));
                rd(0, 0, v); check("R4 in-service readback", v, 8'(1 << n));
                wr(0, 0, 8'h60 + 8'(n));
                rd(0, 0, v); check("R8 eoi clears", v, 8'h00);
                @(negedge clk); m_irq[n] = 0;
            end
        end

        // R11/R12 sweep of slave inputs
        for (int n = 0; n < 8; n++) begin
            @(negedge clk); s_irq[n] = 1;
            wait_cyc(3);
            check("R11 master int via slave", {7'd0, m_int}, 8'h01);
            do_ack();
            check("R11 cascade valid", {7'd0, got_cv}, 8'h01);
            check("R11 cascade index", {5'd0, got_cas}, 8'h02);
            check("R11 master silent", {7'd0, got_mvv}, 8'h00);
            check("R12 slave vector", got_vec, 8'h28 + 8'(n));
            rd(0, 0, v); check("R11 master in-service", v, 8'h04);
            rd(1, 0, v); check("R12 slave in-service", v, 8'(1 << n));
            wr(1, 0, 8'h60 + 8'(n)); wr(0, 0, 8'h62);
            @(negedge clk); s_irq[n] = 0;
            wait_cyc(2);
        end

        // R6 priority and nesting
        @(negedge clk); m_irq[5] = 1; m_irq[3] = 1;
        wait_cyc(2);
        do_ack(); check("R6 lowest index wins", got_vec, 8'h23);
        wait_cyc(1);
        check("R6 blocked by in-service", {7'd0, m_int}, 8'h00);
        @(negedge clk); m_irq[1] = 1;
        wait_cyc(2);
        check("R6 higher level nests", {7'd0, m_int}, 8'h01);
        do_ack(); check("R6 nested vector", got_vec, 8'h21);
        wr(0, 0, 8'h61);
        rd(0, 0, v); check("R8 only level 1 cleared", v, 8'h08);
        check("R6 still blocked", {7'd0, m_int}, 8'h00);
        wr(0, 0, 8'h63);
        wait_cyc(1);
        check("R6 released", {7'd0, m_int}, 8'h01);
        do_ack(); check("R6 remaining vector", got_vec, 8'h25);
        wr(0, 0, 8'h65);
        @(negedge clk); m_irq = 0;

        // R4 pending select
        @(negedge clk); m_irq[6] = 1;
        wait_cyc(2);
        wr(0, 0, 8'h0A);
        rd(0, 0, v); check("R4 pending select", v, 8'h40);

        // R10 spurious with input 7 masked
        wr(0, 1, 8'h80);
        @(negedge clk); m_irq[6] = 0;
        wait_cyc(2);
        check("R10 int dropped", {7'd0, m_int}, 8'h00);
        do_ack();
        check("R10 spurious vector", got_vec, 8'h27);
        check("R10 vector valid", {7'd0, got_mvv}, 8'h01);
        wr(0, 0, 8'h0B);
        rd(0, 0, v); check("R10 no in-service", v, 8'h00);

        // R2/R9 reprogram master: base 0x40, automatic EOI
        wr(0, 0, 8'h11); wr(0, 1, 8'h40); wr(0, 1, 8'h04); wr(0, 1, 8'h03);
        rd(0, 1, v); check("R2 mask kept", v, 8'h80);
        wr(0, 0, 8'h0B);
        @(negedge clk); m_irq[4] = 1;
        wait_cyc(2);
        do_ack(); check("R2 new base", got_vec, 8'h44);
        rd(0, 0, v); check("R9 auto eoi", v, 8'h00);
        @(negedge clk); m_irq[4] = 0;

        // R12 slave ignores ack without matching cascade select
        wr(0, 1, 8'h84);
        @(negedge clk); s_irq[0] = 1; m_irq[0] = 1;
        wait_cyc(3);
        do_ack();
        check("R12 master vector", got_vec, 8'h40);
        check("R12 slave silent", {7'd0, got_svv}, 8'h00);
        wr(1, 0, 8'h0A);
        rd(1, 0, v); check("R12 slave pending kept", v, 8'h01);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule